// File: doc/BRIEF.md
# Late Physical Register Allocator

This block renames destination registers for an out-of-order core in two steps. At rename, each logical destination gets a virtual tag from a small pool sized to the window. No physical register is spent at that point. A physical register is bound only when the instruction produces its result: the completion port asks for a register, and a grant writes the pair (virtual tag, physical register) into a virtual-to-physical map. A request that finds no register available is refused, and the issue logic must replay that instruction later.

To keep the machine from deadlocking, one free physical register is always held back for the oldest in-flight instruction, which is the one whose reorder-buffer index equals the head index. Commit hands back the register bound to the instruction's previous mapping, together with that mapping's virtual tag. A branch checkpoint, followed later by a flush, puts the rename map back and returns every tag and register that was taken after the checkpoint.

Several completions may arrive in one cycle. They are served oldest first, and at most a fixed number of them receive a register from the free list in any one cycle.

Top module: `late_preg_alloc`

## Requirements
- R1: After reset, logical register i maps to virtual tag i. A rename hands out the lowest-numbered free virtual tag on `renVtag` and reports the tag the logical register mapped to before on `renPrevVtag`. The map then points at the new tag from the next cycle on.
- R2: `renReady` is low while no virtual tag is free. A rename presented while `renReady` is low changes neither the map nor the tag pool.
- R3: A granted completion receives a physical register in the same cycle, on its `cplPreg` slice, with `cplGrant` high. The register comes from the free list, lowest number first. After reset, registers 0 to LREGS-1 are bound, register LREGS is reserved and the registers above it are free.
- R4: Requests are ranked by age, where age is (robIdx - robHead) modulo WINDOW. Only the GRANTS oldest non-reserved requests can take free-list registers in a cycle; the others see `cplFail`.
- R5: A request that is not from the oldest instruction fails when the free list is empty, even while a reserved register is held.
- R6: A request whose robIdx equals `robHead` is always granted the reserved register while one is held.
- R7: When the reserved register is used, or is absent at the end of a cycle, the lowest-numbered register that is free after that cycle's grants and releases becomes the new reserved register. The reservation is empty only while the free list is empty.
- R8: A commit frees the virtual tag given on `cmtPrevVtag` and returns the physical register bound to that tag. The returned register can be granted again from the next cycle on.
- R9: `ckptTake` saves the rename map. A later `flush` restores that map and frees every virtual tag renamed since the checkpoint, together with any physical register bound to those tags.
- R10: During a flush cycle no completion is granted, and `renReady` is low.
- R11: Free, bound and reserved physical registers are disjoint, and together they always number exactly PREGS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Rename request |
| renLreg | input | LW | Logical destination being renamed |
| renReady | output | 1 | A virtual tag is available and no flush is under way |
| renVtag | output | VW | Virtual tag given to the rename |
| renPrevVtag | output | VW | Tag the logical register mapped to before the rename |
| ckptTake | input | 1 | Save the rename map as the flush checkpoint |
| robHead | input | RW | Reorder-buffer index of the oldest in-flight instruction |
| cplValid | input | PORTS | Per-port completion request |
| cplVtag | input | PORTS*VW | Per-port virtual tag of the completing instruction |
| cplRob | input | PORTS*RW | Per-port reorder-buffer index |
| cplGrant | output | PORTS | Per-port grant |
| cplFail | output | PORTS | Per-port refusal; the instruction must replay |
| cplPreg | output | PORTS*PW | Per-port granted physical register |
| cmtValid | input | 1 | Commit of the oldest instruction |
| cmtPrevVtag | input | VW | Previous mapping of the committing destination |
| flush | input | 1 | Squash back to the checkpoint |

## Verification
The bench builds the block with four logical registers, seven physical registers, a window of eight, three completion ports and two grants per cycle. With these values only two registers are free after reset. The free list therefore runs dry within a handful of completions, and the refusals, the hand-over of the reserved register and its refill from a commit can all be observed on the ports. Three ports against two grants make the per-cycle limit and the age ranking visible within a single cycle. The twelve-tag pool is small enough that the bench can drain it and show that a refused rename leaves no trace.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
  // control strobes sent from the sequencing logic to the storage
  typedef struct packed {
    logic renDo;
    logic cmtDo;
    logic flushDo;
    logic ckptDo;
    logic resUsed;
  } strobes_t;
endpackage

// File: rtl/lpa_ctrl.sv
module lpa_ctrl import lpa_pkg::*; #(
  parameter int PREGS  = 14,
  parameter int PORTS  = 2,
  parameter int GRANTS = 2,
  parameter int RW     = 3,
  parameter int PW     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  renValid,
  input  logic                  vtagAny,
  input  logic                  cmtValid,
  input  logic                  flush,
  input  logic                  ckptTake,
  input  logic [PORTS-1:0]      cplValid,
  input  logic [PORTS*RW-1:0]   cplRob,
  input  logic [RW-1:0]         robHead,
  input  logic [PREGS-1:0]      freeMask,
  input  logic                  resValid,
  input  logic [PW-1:0]         resPreg,
  output strobes_t              stb,
  output logic                  renReady,
  output logic [PORTS-1:0]      cplGrant,
  output logic [PORTS-1:0]      cplFail,
  output logic [PORTS*PW-1:0]   cplPreg,
  output logic [PREGS-1:0]      grantMask
);
  logic [RW-1:0]     age [PORTS];
  logic [PORTS-1:0]  useRes;
  logic [PORTS-1:0]  normal;
  logic [PW-1:0]     slotPreg [GRANTS];
  logic [GRANTS-1:0] slotOk;
  logic [PW-1:0]     pregOf [PORTS];

  // the GRANTS lowest free registers, one per grant slot
  always_comb begin : slotPick
    logic [PREGS-1:0] avail;
    logic found;
    avail = freeMask;
    for (int g = 0; g < GRANTS; g++) begin
      found = 1'b0;
      slotPreg[g] = '0;
      for (int p = 0; p < PREGS; p++) begin
        if (!found && avail[p]) begin
          found = 1'b1;
          slotPreg[g] = PW'(p);
          avail[p] = 1'b0;
        end
      end
      slotOk[g] = found;
    end
  end

  always_comb begin : ageCalc
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < PORTS; i++) begin
      age[i] = cplRob[i*RW +: RW] - robHead;
      useRes[i] = !taken && !flush && resValid && cplValid[i] && (age[i] == '0);
      if (useRes[i]) taken = 1'b1;
      normal[i] = cplValid[i] && !flush && !useRes[i];
    end
  end

  always_comb begin : grantCalc
    int cnt;
    cplGrant = '0;
    grantMask = '0;
    cplPreg = '0;
    for (int i = 0; i < PORTS; i++) begin
      pregOf[i] = '0;
      cnt = 0;
      for (int j = 0; j < PORTS; j++) begin
        if (normal[j] && ((age[j] < age[i]) || ((age[j] == age[i]) && (j < i)))) cnt++;
      end
      if (useRes[i]) begin
        cplGrant[i] = 1'b1;
        pregOf[i] = resPreg;
      end else if (normal[i]) begin
        for (int g = 0; g < GRANTS; g++) begin
          if (g == cnt && slotOk[g]) begin
            cplGrant[i] = 1'b1;
            pregOf[i] = slotPreg[g];
          end
        end
      end
      if (cplGrant[i]) grantMask[pregOf[i]] = 1'b1;
      cplPreg[i*PW +: PW] = pregOf[i];
    end
    cplFail = cplValid & ~cplGrant;
  end

  assign renReady    = vtagAny && !flush;
  assign stb.renDo   = renValid && vtagAny && !flush;
  assign stb.cmtDo   = cmtValid;
  assign stb.flushDo = flush;
  assign stb.ckptDo  = ckptTake && !flush;
  assign stb.resUsed = |useRes;

  // R10
  flush_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (cplGrant == '0));

  // R4
  grant_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cplGrant & ~useRes) <= GRANTS);

  for (genvar i = 0; i < PORTS; i++) begin : gPortChk
    // R6
    oldest_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cplValid[i] && !flush && resValid && cplRob[i*RW +: RW] == robHead
       && $countones(cplValid) == 1) |-> cplGrant[i]);
    // R5
    young_no_resv_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cplGrant[i] && resValid && cplRob[i*RW +: RW] != robHead)
      |-> (cplPreg[i*PW +: PW] != resPreg));
  end
endmodule

// File: rtl/lpa_data.sv
module lpa_data import lpa_pkg::*; #(
  parameter int LREGS = 8,
  parameter int PREGS = 14,
  parameter int VTAGS = 16,
  parameter int PORTS = 2,
  parameter int LW    = 3,
  parameter int VW    = 4,
  parameter int PW    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             stb,
  input  logic [LW-1:0]        renLreg,
  input  logic [VW-1:0]        cmtPrevVtag,
  input  logic [PORTS-1:0]     cplGrant,
  input  logic [PORTS*VW-1:0]  cplVtag,
  input  logic [PORTS*PW-1:0]  cplPreg,
  input  logic [PREGS-1:0]     grantMask,
  output logic [VW-1:0]        renVtag,
  output logic [VW-1:0]        renPrevVtag,
  output logic                 vtagAny,
  output logic [PREGS-1:0]     freeMask,
  output logic                 resValid,
  output logic [PW-1:0]        resPreg
);
  logic [VW-1:0]    l2v  [LREGS];
  logic [VW-1:0]    ckpt [LREGS];
  logic [PW-1:0]    v2p  [VTAGS];
  logic [VTAGS-1:0] v2pOk, vFree, young;
  logic [VTAGS-1:0] vFreeNext, youngNext, renBit, cmtBit;
  logic [PREGS-1:0] allocMask, relMask, freeNext;
  logic             resNextValid;
  logic [PW-1:0]    resNextPreg;

  always_comb begin
    vtagAny = |vFree;
    renVtag = '0;
    for (int v = VTAGS-1; v >= 0; v--) if (vFree[v]) renVtag = VW'(v);
  end

  assign renPrevVtag = l2v[renLreg];

  always_comb begin
    renBit = '0;
    cmtBit = '0;
    if (stb.renDo) renBit[renVtag] = 1'b1;
    if (stb.cmtDo) cmtBit[cmtPrevVtag] = 1'b1;
    vFreeNext = (vFree & ~renBit) | cmtBit | (stb.flushDo ? young : '0);
    if (stb.flushDo)     youngNext = '0;
    else if (stb.ckptDo) youngNext = renBit;
    else                 youngNext = young | renBit;
  end

  // released registers, then refill of the reservation from what is left free
  always_comb begin
    relMask = '0;
    if (stb.cmtDo && v2pOk[cmtPrevVtag]) relMask[v2p[cmtPrevVtag]] = 1'b1;
    if (stb.flushDo) begin
      for (int v = 0; v < VTAGS; v++) if (young[v] && v2pOk[v]) relMask[v2p[v]] = 1'b1;
    end
    freeNext = (freeMask & ~grantMask) | relMask;
    resNextValid = resValid && !stb.resUsed;
    resNextPreg = resPreg;
    for (int p = 0; p < PREGS; p++) begin
      if (!resNextValid && freeNext[p]) begin
        resNextValid = 1'b1;
        resNextPreg = PW'(p);
        freeNext[p] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < LREGS; l++) begin
        l2v[l]  <= VW'(l);
        ckpt[l] <= VW'(l);
      end
      for (int v = 0; v < VTAGS; v++) begin
        v2p[v]   <= (v < LREGS) ? PW'(v) : '0;
        v2pOk[v] <= (v < LREGS);
        vFree[v] <= (v >= LREGS);
      end
      for (int p = 0; p < PREGS; p++) begin
        allocMask[p] <= (p < LREGS);
        freeMask[p]  <= (p > LREGS);
      end
      young    <= '0;
      resValid <= 1'b1;
      resPreg  <= PW'(LREGS);
    end else begin
      freeMask  <= freeNext;
      allocMask <= (allocMask | grantMask) & ~relMask;
      resValid  <= resNextValid;
      resPreg   <= resNextPreg;
      vFree     <= vFreeNext;
      young     <= youngNext;
      for (int i = 0; i < PORTS; i++) begin
        if (cplGrant[i]) begin
          v2p[cplVtag[i*VW +: VW]]   <= cplPreg[i*PW +: PW];
          v2pOk[cplVtag[i*VW +: VW]] <= 1'b1;
        end
      end
      if (stb.cmtDo) v2pOk[cmtPrevVtag] <= 1'b0;
      if (stb.flushDo) begin
        for (int l = 0; l < LREGS; l++) l2v[l] <= ckpt[l];
        for (int v = 0; v < VTAGS; v++) if (young[v]) v2pOk[v] <= 1'b0;
      end else if (stb.renDo) begin
        l2v[renLreg] <= renVtag;
      end
      if (stb.ckptDo) begin
        for (int l = 0; l < LREGS; l++) ckpt[l] <= l2v[l];
      end
    end
  end

  // R11
  conserve_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(freeMask) + $countones(allocMask) + (resValid ? 1 : 0)) == PREGS);

  // R11
  disjoint_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((freeMask & allocMask) == '0) && !(resValid && (freeMask[resPreg] || allocMask[resPreg])));

  // R7
  resv_refill_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (freeMask == '0));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmtDo && v2pOk[cmtPrevVtag]) |=> !allocMask[$past(v2p[cmtPrevVtag])]);

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.flushDo |=> (young == '0));
endmodule

// File: rtl/late_preg_alloc.sv
module late_preg_alloc import lpa_pkg::*; #(
  parameter int LREGS  = 8,
  parameter int PREGS  = 14,
  parameter int WINDOW = 8,
  parameter int PORTS  = 2,
  parameter int GRANTS = 2,
  localparam int VTAGS = LREGS + WINDOW,
  localparam int LW    = (LREGS > 1) ? $clog2(LREGS) : 1,
  localparam int VW    = $clog2(VTAGS),
  localparam int PW    = $clog2(PREGS),
  localparam int RW    = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 renValid,
  input  logic [LW-1:0]        renLreg,
  output logic                 renReady,
  output logic [VW-1:0]        renVtag,
  output logic [VW-1:0]        renPrevVtag,
  input  logic                 ckptTake,
  input  logic [RW-1:0]        robHead,
  input  logic [PORTS-1:0]     cplValid,
  input  logic [PORTS*VW-1:0]  cplVtag,
  input  logic [PORTS*RW-1:0]  cplRob,
  output logic [PORTS-1:0]     cplGrant,
  output logic [PORTS-1:0]     cplFail,
  output logic [PORTS*PW-1:0]  cplPreg,
  input  logic                 cmtValid,
  input  logic [VW-1:0]        cmtPrevVtag,
  input  logic                 flush
);
  strobes_t         stb;
  logic             vtagAny;
  logic [PREGS-1:0] freeMask;
  logic [PREGS-1:0] grantMask;
  logic             resValid;
  logic [PW-1:0]    resPreg;

  lpa_ctrl #(.PREGS(PREGS), .PORTS(PORTS), .GRANTS(GRANTS), .RW(RW), .PW(PW)) ctrl (
    .clk(clk), .rstN(rstN), .renValid(renValid), .vtagAny(vtagAny),
    .cmtValid(cmtValid), .flush(flush), .ckptTake(ckptTake),
    .cplValid(cplValid), .cplRob(cplRob), .robHead(robHead),
    .freeMask(freeMask), .resValid(resValid), .resPreg(resPreg),
    .stb(stb), .renReady(renReady), .cplGrant(cplGrant), .cplFail(cplFail),
    .cplPreg(cplPreg), .grantMask(grantMask)
  );

  lpa_data #(.LREGS(LREGS), .PREGS(PREGS), .VTAGS(VTAGS), .PORTS(PORTS),
             .LW(LW), .VW(VW), .PW(PW)) data (
    .clk(clk), .rstN(rstN), .stb(stb), .renLreg(renLreg),
    .cmtPrevVtag(cmtPrevVtag), .cplGrant(cplGrant), .cplVtag(cplVtag),
    .cplPreg(cplPreg), .grantMask(grantMask), .renVtag(renVtag),
    .renPrevVtag(renPrevVtag), .vtagAny(vtagAny), .freeMask(freeMask),
    .resValid(resValid), .resPreg(resPreg)
  );
endmodule

// File: tb/late_preg_alloc_test.sv
module late_preg_alloc_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        renValid, renReady, ckptTake, cmtValid, flush;
  logic [1:0]  renLreg;
  logic [3:0]  renVtag, renPrevVtag, cmtPrevVtag;
  logic [2:0]  robHead, cplValid, cplGrant, cplFail;
  logic [11:0] cplVtag;
  logic [8:0]  cplRob, cplPreg;

  late_preg_alloc #(.LREGS(4), .PREGS(7), .WINDOW(8), .PORTS(3), .GRANTS(2)) uut (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renLreg(renLreg),
    .renReady(renReady), .renVtag(renVtag), .renPrevVtag(renPrevVtag),
    .ckptTake(ckptTake), .robHead(robHead), .cplValid(cplValid),
    .cplVtag(cplVtag), .cplRob(cplRob), .cplGrant(cplGrant), .cplFail(cplFail),
    .cplPreg(cplPreg), .cmtValid(cmtValid), .cmtPrevVtag(cmtPrevVtag), .flush(flush)
  );

  int nChk = 0;
  int nErr = 0;

  typedef struct packed {
    logic        ren;
    logic [1:0]  lreg;
    logic        cmt;
    logic [3:0]  cmtV;
    logic [2:0]  head;
    logic [2:0]  cv;
    logic [11:0] cvt;
    logic [8:0]  crob;
    logic [3:0]  eVt;
    logic [3:0]  ePrev;
    logic [2:0]  eG;
    logic [8:0]  ePreg;
    logic [7:0]  req;
  } vec_t;

  // R1 renames, R4 ranking and limit, R5 empty list, R6 reserved, R7 refill, R8 commits, R3 reuse
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd1, 1'b0, 4'd0, 3'd0, 3'b000, 12'h000, 9'd0, 4'd4, 4'd1, 3'b000, 9'd0, 8'd1},
    '{1'b1, 2'd2, 1'b0, 4'd0, 3'd0, 3'b000, 12'h000, 9'd0, 4'd5, 4'd2, 3'b000, 9'd0, 8'd1},
    '{1'b1, 2'd1, 1'b0, 4'd0, 3'd0, 3'b000, 12'h000, 9'd0, 4'd6, 4'd4, 3'b000, 9'd0, 8'd1},
    '{1'b1, 2'd3, 1'b0, 4'd0, 3'd0, 3'b000, 12'h000, 9'd0, 4'd7, 4'd3, 3'b000, 9'd0, 8'd1},
    '{1'b0, 2'd0, 1'b0, 4'd0, 3'd0, 3'b111, 12'h756, {3'd3,3'd1,3'd2}, 4'd0, 4'd0, 3'b011, {3'd0,3'd5,3'd6}, 8'd4},
    '{1'b0, 2'd0, 1'b0, 4'd0, 3'd0, 3'b001, 12'h007, {3'd0,3'd0,3'd3}, 4'd0, 4'd0, 3'b000, 9'd0, 8'd5},
    '{1'b0, 2'd0, 1'b0, 4'd0, 3'd0, 3'b001, 12'h004, 9'd0, 4'd0, 4'd0, 3'b001, {3'd0,3'd0,3'd4}, 8'd6},
    '{1'b0, 2'd0, 1'b1, 4'd1, 3'd0, 3'b000, 12'h000, 9'd0, 4'd0, 4'd0, 3'b000, 9'd0, 8'd8},
    '{1'b0, 2'd0, 1'b1, 4'd2, 3'd1, 3'b000, 12'h000, 9'd0, 4'd0, 4'd0, 3'b000, 9'd0, 8'd8},
    '{1'b0, 2'd0, 1'b0, 4'd0, 3'd2, 3'b001, 12'h007, {3'd0,3'd0,3'd3}, 4'd0, 4'd0, 3'b001, {3'd0,3'd0,3'd2}, 8'd3},
    '{1'b0, 2'd0, 1'b1, 4'd4, 3'd2, 3'b000, 12'h000, 9'd0, 4'd0, 4'd0, 3'b000, 9'd0, 8'd8},
    '{1'b0, 2'd0, 1'b1, 4'd3, 3'd3, 3'b000, 12'h000, 9'd0, 4'd0, 4'd0, 3'b000, 9'd0, 8'd8}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clr();
    renValid = 1'b0; renLreg = '0; ckptTake = 1'b0; cmtValid = 1'b0;
    cmtPrevVtag = '0; flush = 1'b0; cplValid = '0; cplVtag = '0; cplRob = '0;
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    clr();
    robHead = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    renLreg = 2'd3;
    #5;
    check("R1 reset renReady", 32'(renReady), 32'd1);
    check("R1 reset first tag", 32'(renVtag), 32'd4);
    check("R1 reset mapping", 32'(renPrevVtag), 32'd3);
    check("R3 no request no grant", 32'(cplGrant), 32'd0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      clr();
      renValid = VECS[k].ren; renLreg = VECS[k].lreg;
      cmtValid = VECS[k].cmt; cmtPrevVtag = VECS[k].cmtV;
      robHead = VECS[k].head; cplValid = VECS[k].cv;
      cplVtag = VECS[k].cvt; cplRob = VECS[k].crob;
      #5;
      if (VECS[k].ren) begin
        check($sformatf("R%0d vec%0d tag", VECS[k].req, k), 32'(renVtag), 32'(VECS[k].eVt));
        check($sformatf("R%0d vec%0d prev", VECS[k].req, k), 32'(renPrevVtag), 32'(VECS[k].ePrev));
      end
      check($sformatf("R%0d vec%0d grant", VECS[k].req, k), 32'(cplGrant), 32'(VECS[k].eG));
      check($sformatf("R%0d vec%0d fail", VECS[k].req, k), 32'(cplFail), 32'(VECS[k].cv & ~VECS[k].eG));
      for (int p = 0; p < 3; p++) begin
        if (VECS[k].eG[p])
          check($sformatf("R%0d vec%0d preg%0d", VECS[k].req, k, p),
                32'(cplPreg[p*3 +: 3]), 32'(VECS[k].ePreg[p*3 +: 3]));
      end
    end

    // checkpoint, two renames, a bind, then flush: R9 and R10
    @(negedge clk); clr(); robHead = 3'd4; ckptTake = 1'b1;
    @(negedge clk); clr(); renValid = 1'b1; renLreg = 2'd0; #5;
    check("R1 lowest freed tag", 32'(renVtag), 32'd1);
    check("R1 prev of lreg0", 32'(renPrevVtag), 32'd0);
    @(negedge clk); clr(); renValid = 1'b1; renLreg = 2'd2; #5;
    check("R1 tag after ckpt", 32'(renVtag), 32'd2);
    check("R1 prev of lreg2", 32'(renPrevVtag), 32'd5);
    @(negedge clk); clr(); cplValid = 3'b001; cplVtag = 12'h002; cplRob = 9'd5; #5;
    check("R3 young bind", 32'(cplGrant), 32'b001);
    check("R3 young bind reg", 32'(cplPreg[2:0]), 32'd3);
    @(negedge clk); clr(); flush = 1'b1; cplValid = 3'b001; cplVtag = 12'h001; cplRob = 9'd4; #5;
    check("R10 flush blocks oldest", 32'(cplGrant), 32'd0);
    check("R10 flush fail", 32'(cplFail), 32'b001);
    check("R10 flush renReady", 32'(renReady), 32'd0);
    @(negedge clk); clr(); renValid = 1'b1; renLreg = 2'd0; #5;
    check("R9 tag freed", 32'(renVtag), 32'd1);
    check("R9 map restored lreg0", 32'(renPrevVtag), 32'd0);
    @(negedge clk); clr(); renValid = 1'b1; renLreg = 2'd2; #5;
    check("R9 map restored lreg2", 32'(renPrevVtag), 32'd5);
    @(negedge clk); clr();
    cplValid = 3'b011; cplVtag = {4'd0, 4'd1, 4'd2}; cplRob = {3'd0, 3'd4, 3'd5}; #5;
    check("R6 oldest plus young", 32'(cplGrant), 32'b011);
    check("R6 oldest takes reserved", 32'(cplPreg[5:3]), 32'd1);
    check("R9 flushed reg back", 32'(cplPreg[2:0]), 32'd3);
    @(negedge clk); clr(); renValid = 1'b1; renLreg = 2'd3; #5;
    check("R1 tag3", 32'(renVtag), 32'd3);
    @(negedge clk); clr(); cplValid = 3'b001; cplVtag = 12'h003; cplRob = 9'd6; #5;
    check("R5 reserve held from young", 32'(cplFail), 32'b001);

    // drain the tag pool: R2
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); clr(); renValid = 1'b1; renLreg = 2'(k % 4); #5;
      check("R1 drain tag", 32'(renVtag), (k == 0) ? 32'd4 : 32'(7 + k));
    end
    @(negedge clk); clr(); renValid = 1'b1; renLreg = 2'd1; #5;
    check("R2 pool empty", 32'(renReady), 32'd0);
    @(negedge clk); clr(); cmtValid = 1'b1; cmtPrevVtag = 4'd0; #5;
    check("R2 still empty in commit cycle", 32'(renReady), 32'd0);
    @(negedge clk); clr(); renValid = 1'b1; renLreg = 2'd1; #5;
    check("R8 tag returned", 32'(renReady), 32'd1);
    check("R8 returned tag handed out", 32'(renVtag), 32'd0);
    check("R2 ignored rename left map", 32'(renPrevVtag), 32'd8);
    @(negedge clk); clr(); cplValid = 3'b001; cplVtag = 12'h004; cplRob = 9'd7; #5;
    check("R8 released reg granted", 32'(cplGrant), 32'b001);
    check("R8 released reg number", 32'(cplPreg[2:0]), 32'd0);
    @(negedge clk); clr();
    @(negedge clk);
    finish();
  end
endmodule